// File: doc/BRIEF.md
# Sub-page write permission walker

This block rules on a single guest write to a 4 KB page and answers at a finer grain: each page is split into 32 regions of 128 bytes, and each region may be writable or not. A request brings the guest-physical address of the write, the 64-bit leaf translation entry that maps the page, and a flag for non-maskable-interrupt unblocking. Two side inputs are sampled at the same time: a global enable for the region check and the 4 KB-aligned root of the permission table.

Most requests resolve from the leaf entry alone. The leaf entry's own write bit (bit 1) grants the write outright. When that bit is clear, the sub-page marker (bit 61) is set, and the global enable is on, the block walks a four-level permission table through a one-outstanding memory read port. The final level entry holds one write bit per region. A walk that finds an absent entry reports a table miss. A walk that finds a reserved bit set reports a table misconfiguration. Both outcomes carry an exit reason code and an exit qualification word for the surrounding exit logic.

Each accepted request yields exactly one result on a valid/ready output. The block takes a new request only while idle.

Top module: `subpage_walker`

## Requirements
- R1: `reqReady` is 1 exactly when `busy` is 0. `busy` rises in the cycle after a request is accepted and stays 1 until the result handshake. After reset the block is idle with `resValid` and `memReqValid` at 0.
- R2: When `sppEnable` is 0 or leaf bit 61 is 0, no memory read is issued. `resValid` is 1 in the cycle after acceptance, with result code 0 (allow) if leaf bit 1 is 1 and code 1 (violation) otherwise.
- R3: When leaf bit 1 is 1, the result is allow (code 0) without any memory read, whatever bit 61 and `sppEnable` hold.
- R4: When `sppEnable` is 1, leaf bit 61 is 1 and leaf bit 1 is 0, the block reads entries for levels 4, 3, 2 and 1, in that order. Each entry address is the table base plus 8 times a 9-bit index; the index is GPA bits 47:39, 38:30, 29:21 and 20:12 respectively. The first base is `tableRoot`, and each later base is bits PA_W-1:12 of the entry just read. `memReqAddr` holds steady while a request waits for `memReqReady`.
- R5: A level 4, 3 or 2 entry with any of bits 11:1 or bits 63:PA_W set ends the walk as a misconfiguration (code 3). No further read is issued.
- R6: A level 4, 3 or 2 entry with bit 0 clear and no reserved bit set ends the walk as a miss (code 2). No further read is issued.
- R7: A level 1 entry with any odd-numbered bit set gives a misconfiguration (code 3).
- R8: Otherwise, level 1 bit 2*GPA[11:7] decides the result: 1 gives allow (code 0) and 0 gives violation (code 1).
- R9: For a miss or a misconfiguration, `resExitReason` is 66. `resExitQual` bit 11 is 1 for a miss and 0 for a misconfiguration, bit 12 is the `reqNmiUnblock` value taken at acceptance, and all other bits are 0. For allow and violation, both fields are 0.
- R10: While `resValid` is 1 and `resReady` is 0, the result and its fields hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request offered |
| reqReady | output | 1 | Block idle and taking a request |
| reqGpa | input | GPA_W | Guest-physical address of the write |
| reqLeaf | input | 64 | Leaf translation entry mapping the page |
| reqNmiUnblock | input | 1 | Flag copied into qualification bit 12 |
| sppEnable | input | 1 | Global enable of the region check |
| tableRoot | input | PA_W | 4 KB-aligned root of the permission table |
| memReqValid | output | 1 | Table read request |
| memReqReady | input | 1 | Memory takes the read |
| memReqAddr | output | PA_W | Byte address of the entry to read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Entry value |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Consumer takes the result |
| resCode | output | 2 | 0 allow, 1 violation, 2 miss, 3 misconfiguration |
| resExitReason | output | 16 | 66 for miss or misconfiguration, else 0 |
| resExitQual | output | 64 | Exit qualification word |
| busy | output | 1 | Request in progress |

## Verification
A decision from the leaf entry alone is due one cycle after acceptance, so the bench checks `resValid` and the fields at the first falling edge after the accepting edge. A walk result is due one cycle after the response that ends the walk, and that time depends on memory stalls. The bench therefore polls `resValid` at falling edges under a bound. It then checks the number and the addresses of the reads its memory model logged, which shows the walk stopped where it should. The hold test keeps `resReady` low for several falling edges and compares the fields at each of them.

// File: rtl/swalk_pkg.sv
package swalk_pkg;

  typedef enum logic [1:0] {
    RES_ALLOW     = 2'd0,
    RES_VIOLATE   = 2'd1,
    RES_MISS      = 2'd2,
    RES_MISCONFIG = 2'd3
  } walkRes_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request fields, load root, level 4
    logic fastDone;  // result decided from the leaf entry alone
    logic descend;   // entry valid: load next base, step a level down
    logic walkDone;  // walk ended: latch the response verdict
  } dpStrobe_t;

  localparam int LEAF_WRITE_BIT = 1;
  localparam int LEAF_SPP_BIT   = 61;
  localparam int EXIT_CODE_SPP  = 66;
  localparam int LEVEL_IDX_W    = 9;
  localparam int PAGE_SHIFT     = 12;
  localparam int REGIONS        = 32;

endpackage

// File: rtl/swalk_datapath.sv
module swalk_datapath
  import swalk_pkg::*;
#(
  parameter int PA_W     = 52,
  parameter int GPA_W    = 48,
  parameter int REASON_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [GPA_W-1:0]    reqGpa,
  input  logic [63:0]         reqLeaf,
  input  logic                reqNmiUnblock,
  input  logic                sppEnable,
  input  logic [PA_W-1:0]     tableRoot,
  input  logic [63:0]         memRspData,
  output logic                needWalk,
  output logic                rspDescend,
  output logic [PA_W-1:0]     memReqAddr,
  output logic [1:0]          resCode,
  output logic [REASON_W-1:0] resExitReason,
  output logic [63:0]         resExitQual
);

  localparam int BASE_W = PA_W - PAGE_SHIFT;

  logic [GPA_W-1:0]       gpaQ;
  logic                   nmiQ;
  logic [BASE_W-1:0]      baseQ;
  logic [1:0]             levelQ;   // 3 = level 4 ... 0 = level 1
  walkRes_t               resQ;

  logic [LEVEL_IDX_W-1:0] tableIdx;
  logic                   rsvdSet;
  logic [REGIONS-1:0]     permBits;
  logic [REGIONS-1:0]     oddBits;
  walkRes_t               fastRes;
  walkRes_t               rspRes;

  // request classification
  assign needWalk = sppEnable && reqLeaf[LEAF_SPP_BIT] && !reqLeaf[LEAF_WRITE_BIT];
  assign fastRes  = reqLeaf[LEAF_WRITE_BIT] ? RES_ALLOW : RES_VIOLATE;

  // entry address for the current level
  assign tableIdx   = gpaQ[PAGE_SHIFT + LEVEL_IDX_W*int'(levelQ) +: LEVEL_IDX_W];
  assign memReqAddr = {baseQ, tableIdx, 3'b000};

  // upper-level entry reserved fields
  assign rsvdSet = (|memRspData[PAGE_SHIFT-1:1]) || (|memRspData[63:PA_W]);

  // split the level 1 entry into permission and reserved bits
  for (genvar g = 0; g < REGIONS; g++) begin : g_region
    assign permBits[g] = memRspData[2*g];
    assign oddBits[g]  = memRspData[2*g+1];
  end

  always_comb begin
    rspDescend = 1'b0;
    if (levelQ != 2'd0) begin
      if (rsvdSet)             rspRes = RES_MISCONFIG;
      else if (!memRspData[0]) rspRes = RES_MISS;
      else begin
        rspRes     = RES_ALLOW;
        rspDescend = 1'b1;
      end
    end else begin
      if (|oddBits)                 rspRes = RES_MISCONFIG;
      else if (permBits[gpaQ[11:7]]) rspRes = RES_ALLOW;
      else                          rspRes = RES_VIOLATE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpaQ   <= '0;
      nmiQ   <= 1'b0;
      baseQ  <= '0;
      levelQ <= 2'd3;
      resQ   <= RES_ALLOW;
    end else begin
      if (strobe.capture) begin
        gpaQ   <= reqGpa;
        nmiQ   <= reqNmiUnblock;
        baseQ  <= tableRoot[PA_W-1:PAGE_SHIFT];
        levelQ <= 2'd3;
      end
      if (strobe.fastDone) resQ <= fastRes;
      if (strobe.descend) begin
        baseQ  <= memRspData[PA_W-1:PAGE_SHIFT];
        levelQ <= levelQ - 2'd1;
      end
      if (strobe.walkDone) resQ <= rspRes;
    end
  end

  // result fields
  always_comb begin
    resCode       = resQ;
    resExitReason = '0;
    resExitQual   = '0;
    if (resQ == RES_MISS || resQ == RES_MISCONFIG) begin
      resExitReason   = REASON_W'(EXIT_CODE_SPP);
      resExitQual[11] = (resQ == RES_MISS);
      resExitQual[12] = nmiQ;
    end
  end

endmodule

// File: rtl/swalk_ctrl.sv
module swalk_ctrl
  import swalk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      needWalk,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      rspDescend,
  input  logic      resReady,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      resValid,
  output logic      busy,
  output dpStrobe_t strobe
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2,
    ST_HOLD  = 2'd3
  } ctrlState_t;

  ctrlState_t stateQ, stateD;

  assign reqReady    = (stateQ == ST_IDLE);
  assign busy        = (stateQ != ST_IDLE);
  assign memReqValid = (stateQ == ST_ISSUE);
  assign resValid    = (stateQ == ST_HOLD);

  always_comb begin
    strobe          = '0;
    strobe.capture  = (stateQ == ST_IDLE) && reqValid;
    strobe.fastDone = strobe.capture && !needWalk;
    strobe.descend  = (stateQ == ST_AWAIT) && memRspValid && rspDescend;
    strobe.walkDone = (stateQ == ST_AWAIT) && memRspValid && !rspDescend;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (reqValid)    stateD = needWalk ? ST_ISSUE : ST_HOLD;
      ST_ISSUE: if (memReqReady) stateD = ST_AWAIT;
      ST_AWAIT: if (memRspValid) stateD = rspDescend ? ST_ISSUE : ST_HOLD;
      ST_HOLD:  if (resReady)    stateD = ST_IDLE;
      default:                   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/subpage_walker.sv
module subpage_walker
  import swalk_pkg::*;
#(
  parameter int PA_W     = 52,
  parameter int GPA_W    = 48,
  parameter int REASON_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [GPA_W-1:0]    reqGpa,
  input  logic [63:0]         reqLeaf,
  input  logic                reqNmiUnblock,
  input  logic                sppEnable,
  input  logic [PA_W-1:0]     tableRoot,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [PA_W-1:0]     memReqAddr,
  input  logic                memRspValid,
  input  logic [63:0]         memRspData,
  output logic                resValid,
  input  logic                resReady,
  output logic [1:0]          resCode,
  output logic [REASON_W-1:0] resExitReason,
  output logic [63:0]         resExitQual,
  output logic                busy
);

  dpStrobe_t strobe;
  logic      needWalk;
  logic      rspDescend;

  swalk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .needWalk   (needWalk),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspDescend (rspDescend),
    .resReady   (resReady),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .resValid   (resValid),
    .busy       (busy),
    .strobe     (strobe)
  );

  swalk_datapath #(
    .PA_W    (PA_W),
    .GPA_W   (GPA_W),
    .REASON_W(REASON_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqGpa       (reqGpa),
    .reqLeaf      (reqLeaf),
    .reqNmiUnblock(reqNmiUnblock),
    .sppEnable    (sppEnable),
    .tableRoot    (tableRoot),
    .memRspData   (memRspData),
    .needWalk     (needWalk),
    .rspDescend   (rspDescend),
    .memReqAddr   (memReqAddr),
    .resCode      (resCode),
    .resExitReason(resExitReason),
    .resExitQual  (resExitQual)
  );

endmodule

// File: rtl/swalk_checker.sv
module swalk_checker #(
  parameter int PA_W     = 52,
  parameter int REASON_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [63:0]         reqLeaf,
  input logic                sppEnable,
  input logic                memReqValid,
  input logic                memReqReady,
  input logic [PA_W-1:0]     memReqAddr,
  input logic                resValid,
  input logic                resReady,
  input logic [1:0]          resCode,
  input logic [REASON_W-1:0] resExitReason,
  input logic [63:0]         resExitQual,
  input logic                busy
);

  // R1: accepting a request makes the block busy on the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  // R2: leaf-only decision yields a result next cycle with no read
  p_fast_no_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !(sppEnable && reqLeaf[61] && !reqLeaf[1]))
      |=> (resValid && !memReqValid));

  // R3: leaf write bit grants the write
  p_leaf_write_allow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLeaf[1]) |=> (resValid && resCode == 2'd0));

  // R4: a pending table read keeps its address
  p_read_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R6: no read is in flight once a result stands
  p_no_read_with_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !memReqValid);

  // R9: exit reason tracks the miss and misconfiguration codes
  p_exit_reason_r9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ((resCode[1] == 1'b1) == (resExitReason == REASON_W'(66))));

  // R9: only qualification bits 11 and 12 may be set
  p_qual_zero_bits_r9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ((resExitQual & ~64'h1800) == 64'h0));

  // R10: result held while not taken
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resCode)
      && $stable(resExitReason) && $stable(resExitQual)));

endmodule

bind subpage_walker swalk_checker #(.PA_W(PA_W), .REASON_W(REASON_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqLeaf      (reqLeaf),
  .sppEnable    (sppEnable),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqAddr   (memReqAddr),
  .resValid     (resValid),
  .resReady     (resReady),
  .resCode      (resCode),
  .resExitReason(resExitReason),
  .resExitQual  (resExitQual),
  .busy         (busy)
);

// File: tb/subpage_walker_test.sv
`timescale 1ns/1ps
module subpage_walker_test;

  localparam int PA_W  = 52;
  localparam int GPA_W = 48;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [GPA_W-1:0]  reqGpa = '0;
  logic [63:0]       reqLeaf = '0;
  logic              reqNmiUnblock = 1'b0;
  logic              sppEnable = 1'b0;
  logic [PA_W-1:0]   tableRoot = '0;
  logic              memReqValid;
  logic              memReqReady = 1'b1;
  logic [PA_W-1:0]   memReqAddr;
  logic              memRspValid = 1'b0;
  logic [63:0]       memRspData = '0;
  logic              resValid;
  logic              resReady = 1'b1;
  logic [1:0]        resCode;
  logic [15:0]       resExitReason;
  logic [63:0]       resExitQual;
  logic              busy;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;   // 125 MHz

  subpage_walker #(.PA_W(PA_W), .GPA_W(GPA_W)) uut (.*);

  // ---------------- memory model ----------------
  logic [PA_W-1:0] memAddr [16];
  logic [63:0]     memData [16];
  int              memCnt = 0;
  logic [PA_W-1:0] logAddr [8];
  int              logCnt = 0;
  bit              stallMode = 0;
  bit              pend = 0;
  logic [63:0]     pendData = '0;
  int              cyc = 0;

  function automatic logic [63:0] lookup(input logic [PA_W-1:0] a);
    lookup = '0;
    for (int i = 0; i < memCnt; i++) if (memAddr[i] == a) lookup = memData[i];
  endfunction

  task automatic memPut(input logic [PA_W-1:0] a, input logic [63:0] d);
    memAddr[memCnt] = a;
    memData[memCnt] = d;
    memCnt++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      memRspValid = 1'b0;
      if (pend) begin
        memRspValid = 1'b1;
        memRspData  = pendData;
        pend = 0;
      end
      memReqReady = stallMode ? cyc[0] : 1'b1;
      if (memReqValid && memReqReady) begin
        if (logCnt < 8) logAddr[logCnt] = memReqAddr;
        logCnt++;
        pendData = lookup(memReqAddr);
        pend = 1;
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  localparam logic [63:0] LEAF_SPP = 64'h1 << 61;
  localparam logic [63:0] LEAF_WR  = 64'h2;
  localparam logic [PA_W-1:0] ROOT = 52'h0_0000_0010_0000;
  localparam logic [PA_W-1:0] T3   = 52'h0_0000_0020_0000;
  localparam logic [PA_W-1:0] T2   = 52'h0_0000_0030_0000;
  localparam logic [PA_W-1:0] T1   = 52'h0_0000_0040_0000;
  localparam logic [8:0] I4 = 9'h011, I3 = 9'h022, I2 = 9'h133, I1 = 9'h0A4;

  function automatic logic [GPA_W-1:0] mkGpa(input logic [4:0] region);
    mkGpa = {I4, I3, I2, I1, region, 7'h12};
  endfunction

  function automatic logic [PA_W-1:0] entAddr(input logic [PA_W-1:0] base,
                                               input logic [8:0] idx);
    entAddr = base + PA_W'(idx) * 8;
  endfunction

  // full valid chain with the given level 1 entry
  task automatic buildChain(input logic [63:0] l4, input logic [63:0] l3,
                            input logic [63:0] l2, input logic [63:0] l1);
    memCnt = 0;
    memPut(entAddr(ROOT, I4), l4);
    memPut(entAddr(T3, I3), l3);
    memPut(entAddr(T2, I2), l2);
    memPut(entAddr(T1, I1), l1);
  endtask

  task automatic issue(input logic [GPA_W-1:0] gpa, input logic [63:0] leaf,
                       input bit en, input bit nmi);
    @(negedge clk);
    reqGpa = gpa; reqLeaf = leaf; sppEnable = en; reqNmiUnblock = nmi;
    tableRoot = ROOT; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // leaf-only decision: result due at the first negedge after acceptance
  task automatic fastCase(input string req, input logic [63:0] leaf, input bit en,
                          input logic [1:0] expCode);
    int reads0;
    reads0 = logCnt;
    issue(mkGpa(5'd3), leaf, en, 1'b1);
    chk(resValid == 1'b1, {req, " result next cycle"}, 64'(resValid), 64'd1);
    chk(resCode == expCode, {req, " code"}, 64'(resCode), 64'(expCode));
    chk(resExitReason == 16'd0 && resExitQual == 64'd0, "R9 non-exit fields zero",
        {resExitQual[47:0], resExitReason}, 64'd0);
    @(negedge clk);
    chk(logCnt == reads0, {req, " no table read"}, 64'(logCnt - reads0), 64'd0);
    chk(busy == 1'b0, "R1 idle after handshake", 64'(busy), 64'd0);
  endtask

  task automatic walkCase(input string req, input logic [GPA_W-1:0] gpa, input bit nmi,
                          input logic [1:0] expCode, input int expReads,
                          input logic [63:0] expQual);
    int n;
    logCnt = 0;
    issue(gpa, LEAF_SPP, 1'b1, nmi);
    chk(busy == 1'b1 && reqReady == 1'b0, "R1 busy during walk", 64'(busy), 64'd1);
    n = 0;
    while (!resValid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(resValid == 1'b1, {req, " result arrives"}, 64'(resValid), 64'd1);
    chk(resCode == expCode, {req, " code"}, 64'(resCode), 64'(expCode));
    chk(logCnt == expReads, {req, " read count"}, 64'(logCnt), 64'(expReads));
    chk(resExitQual == expQual, "R9 qualification", resExitQual, expQual);
    chk(resExitReason == ((expCode >= 2) ? 16'd66 : 16'd0), "R9 exit reason",
        64'(resExitReason), (expCode >= 2) ? 64'd66 : 64'd0);
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    chk(reqReady == 1'b1 && busy == 1'b0, "R1 reset idle", 64'(busy), 64'd0);
    chk(resValid == 1'b0 && memReqValid == 1'b0, "R1 reset outputs quiet",
        64'({resValid, memReqValid}), 64'd0);
  endtask

  task automatic testLeafOnly();
    fastCase("R2 enable off", LEAF_SPP, 1'b0, 2'd1);
    fastCase("R2 spp bit clear writable", LEAF_WR, 1'b1, 2'd0);
    fastCase("R2 spp bit clear read-only", 64'h0, 1'b1, 2'd1);
    fastCase("R3 writable ignores spp", LEAF_SPP | LEAF_WR, 1'b1, 2'd0);
  endtask

  task automatic testWalkAllow();
    buildChain({12'h0, T3} | 64'h1, {12'h0, T2} | 64'h1, {12'h0, T1} | 64'h1,
               64'h1 << 10);
    stallMode = 1;
    walkCase("R8 region 5 allowed", mkGpa(5'd5), 1'b1, 2'd0, 4, 64'h0);
    stallMode = 0;
    chk(logAddr[0] == entAddr(ROOT, I4), "R4 level 4 address", 64'(logAddr[0]),
        64'(entAddr(ROOT, I4)));
    chk(logAddr[1] == entAddr(T3, I3), "R4 level 3 address", 64'(logAddr[1]),
        64'(entAddr(T3, I3)));
    chk(logAddr[2] == entAddr(T2, I2), "R4 level 2 address", 64'(logAddr[2]),
        64'(entAddr(T2, I2)));
    chk(logAddr[3] == entAddr(T1, I1), "R4 level 1 address", 64'(logAddr[3]),
        64'(entAddr(T1, I1)));
  endtask

  task automatic testWalkDeny();
    buildChain({12'h0, T3} | 64'h1, {12'h0, T2} | 64'h1, {12'h0, T1} | 64'h1,
               64'h5555_5555_5555_5555 & ~(64'h1 << 10));
    walkCase("R8 region 5 denied", mkGpa(5'd5), 1'b0, 2'd1, 4, 64'h0);
    buildChain({12'h0, T3} | 64'h1, {12'h0, T2} | 64'h1, {12'h0, T1} | 64'h1,
               64'h1 << 62);
    walkCase("R8 last region allowed", mkGpa(5'd31), 1'b0, 2'd0, 4, 64'h0);
    walkCase("R8 first region denied", mkGpa(5'd0), 1'b0, 2'd1, 4, 64'h0);
  endtask

  task automatic testFaults();
    // level 1 odd bit
    buildChain({12'h0, T3} | 64'h1, {12'h0, T2} | 64'h1, {12'h0, T1} | 64'h1,
               (64'h1 << 10) | 64'h8);
    walkCase("R7 level 1 odd bit", mkGpa(5'd5), 1'b0, 2'd3, 4, 64'h0);
    // level 3 absent entry -> miss after two reads
    memCnt = 0;
    memPut(entAddr(ROOT, I4), {12'h0, T3} | 64'h1);
    walkCase("R6 level 3 miss", mkGpa(5'd5), 1'b1, 2'd2, 2, 64'h1800);
    // level 2 reserved low bit
    buildChain({12'h0, T3} | 64'h1, {12'h0, T2} | 64'h1,
               {12'h0, T1} | 64'h21, 64'h1 << 10);
    walkCase("R5 level 2 low reserved", mkGpa(5'd5), 1'b0, 2'd3, 3, 64'h0);
    // level 4 reserved high bit
    buildChain({12'h0, T3} | 64'h1 | (64'h1 << 60), {12'h0, T2} | 64'h1,
               {12'h0, T1} | 64'h1, 64'h1 << 10);
    walkCase("R5 level 4 high reserved", mkGpa(5'd5), 1'b1, 2'd3, 1, 64'h1000);
  endtask

  task automatic testHold();
    memCnt = 0;
    resReady = 1'b0;
    logCnt = 0;
    issue(mkGpa(5'd7), LEAF_SPP, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(resValid == 1'b1 && resCode == 2'd2, "R10 miss result held",
          64'(resCode), 64'd2);
      chk(resExitQual == 64'h800, "R10 qualification held", resExitQual, 64'h800);
      chk(reqReady == 1'b0, "R1 no acceptance while result pending",
          64'(reqReady), 64'd0);
      @(negedge clk);
    end
    resReady = 1'b1;
    @(negedge clk);
    chk(resValid == 1'b0 && reqReady == 1'b1, "R1 idle after release",
        64'(resValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLeafOnly();
    testWalkAllow();
    testWalkDeny();
    testFaults();
    testHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule